// File: doc/BRIEF.md
# Fifth-Order Sinc Decimation Filter

This block turns the single-bit output of a delta-sigma modulator into 24-bit signed conversion words. It makes its own modulator sample strobe by dividing the system clock by six and hands that strobe to the modulator. Each modulator bit counts as +1 when high and −1 when low. The bits pass through five cascaded integrators. The integrator output is then decimated by 64 and fed through five cascaded differencing stages, which gives a weighted average over the last 320 samples. A new word appears every 384 system clocks, marked by a one-clock strobe.

The full-precision sum is scaled down to 24 bits and clamped, so a full-scale positive input reads 7FFFFF and never wraps. The filter takes five output periods to forget its starting state. For that reason a settled flag stays low, and the output word is held at zero, for the first five words after a reset or a synchronous clear. Both come good on the sixth word. The synchronous clear lets several converters restart their conversion grid on the same clock.

Top module: `sinc5_decim`

## Requirements
- R1: `mod_tick` pulses high for exactly one clock once every 6 system clocks. The modulator bit is sampled on the clock edges where `mod_tick` is high.
- R2: `result_valid` pulses high for exactly one clock once every 384 system clocks, which is 64 modulator samples.
- R3: Once settled, the word is the two's-complement mean of the input (bit 1 = +1, bit 0 = −1) scaled so that a mean of 1.0 corresponds to 2^23. A repeating 1,0 input gives 000000. A repeating 1,1,1,0 input gives 400000. A repeating 1,0,0,0 input gives C00000.
- R4: An input of all zeros gives exactly 800000, the negative full-scale code.
- R5: An input of all ones saturates to exactly 7FFFFF and does not wrap to a negative code.
- R6: After a reset or a synchronous clear, `settled` is low for the first five `result_valid` strobes. It rises together with the sixth strobe and stays high until the next clear.
- R7: On every strobe while `settled` is low, `result` reads 000000.
- R8: A one-clock `sync_clr` clears the divider, the filter state and the settle count. Afterwards the first strobe arrives with the same latency as after reset. The first settled word depends only on the input applied after the clear.
- R9: While `rst` is high, `result`, `result_valid`, `settled` and `mod_tick` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_clr | input | 1 | Synchronous clear of all filter state, used to realign converters |
| mod_bit | input | 1 | Modulator output bit, sampled when `mod_tick` is high |
| mod_tick | output | 1 | Modulator sample strobe, system clock divided by six |
| result | output | 24 | Conversion word, two's complement |
| result_valid | output | 1 | One-clock strobe marking a new `result` |
| settled | output | 1 | High once the filter has fully settled |

## Verification
The hardest condition to reach is the positive full-scale case. There the true filter sum is exactly 2^30, one count beyond what the output range can hold. Only an unbroken run of ones lasting more than five output periods gets there, so the bench holds that input from reset through the settle window and then checks for the clamped code. The bench also exercises the synchronous clear mid-run, switching to a different input pattern at the same moment. This shows that no state from before the clear leaks into the sixth word after it, and that the strobe latency matches the latency after reset.

// File: rtl/sinc5_pkg.sv
package sinc5_pkg;
  localparam int unsigned DEF_DIV   = 6;
  localparam int unsigned DEF_LOG2R = 6;
  localparam int unsigned DEF_ORDER = 5;
  localparam int unsigned DEF_OW    = 24;

  function automatic int unsigned acc_width(input int unsigned order, input int unsigned log2r);
    return order * log2r + 2;
  endfunction
endpackage

// File: rtl/sinc_tick_gen.sv
module sinc_tick_gen #(
  parameter int unsigned DIV   = 6,
  parameter int unsigned LOG2R = 6
) (
  input  logic clk,
  input  logic clr,
  output logic tick,
  output logic dec_en
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);
  localparam logic [LOG2R-1:0] PH_LAST = '1;

  logic [CW-1:0]    cnt;
  logic [LOG2R-1:0] phase;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt    <= '0;
      tick   <= 1'b0;
      phase  <= '0;
      dec_en <= 1'b0;
    end else begin
      if (cnt == CNT_LAST) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        tick <= 1'b0;
      end
      if (tick) phase <= phase + 1'b1;
      dec_en <= tick && (phase == PH_LAST);
    end
  end

  logic [CW:0] gap;
  logic        gap_seen;
  always_ff @(posedge clk) begin
    if (clr) begin
      gap      <= '0;
      gap_seen <= 1'b0;
    end else begin
      gap      <= tick ? '0 : gap + 1'b1;
      if (tick) gap_seen <= 1'b1;
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (clr)
    (tick && gap_seen) |-> (gap == (CW+1)'(DIV - 1))); // R1
endmodule

// File: rtl/sinc_integ_chain.sv
module sinc_integ_chain #(
  parameter int unsigned ORDER = 5,
  parameter int unsigned AW    = 32
) (
  input  logic                 clk,
  input  logic                 clr,
  input  logic                 tick,
  input  logic                 bit_in,
  output logic signed [AW-1:0] acc_out
);
  logic signed [AW-1:0] step;
  assign step = {{(AW-1){~bit_in}}, 1'b1};

  for (genvar g = 0; g < ORDER; g++) begin : stg
    logic signed [AW-1:0] q;
    logic signed [AW-1:0] add;
    if (g == 0) begin : first
      assign add = step;
    end else begin : chain
      assign add = stg[g-1].q;
    end
    always_ff @(posedge clk) begin
      if (clr)       q <= '0;
      else if (tick) q <= q + add;
    end
  end

  assign acc_out = stg[ORDER-1].q;
endmodule

// File: rtl/sinc_comb_out.sv
module sinc_comb_out #(
  parameter int unsigned ORDER = 5,
  parameter int unsigned LOG2R = 6,
  parameter int unsigned AW    = 32,
  parameter int unsigned OW    = 24
) (
  input  logic                 clk,
  input  logic                 clr,
  input  logic                 dec_en,
  input  logic signed [AW-1:0] acc_in,
  output logic [OW-1:0]        result,
  output logic                 result_valid,
  output logic                 settled
);
  localparam int unsigned SHIFT = ORDER * LOG2R + 1 - OW;
  localparam int unsigned SW    = $clog2(ORDER + 1);
  localparam logic [SW-1:0] SETTLE = SW'(ORDER);
  localparam logic signed [AW-1:0] MAXV = {{(AW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [AW-1:0] MINV = {{(AW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  for (genvar g = 0; g < ORDER; g++) begin : cmb
    logic signed [AW-1:0] din;
    logic signed [AW-1:0] dout;
    logic signed [AW-1:0] dly;
    if (g == 0) begin : first
      assign din = acc_in;
    end else begin : chain
      assign din = cmb[g-1].dout;
    end
    assign dout = din - dly;
    always_ff @(posedge clk) begin
      if (clr)         dly <= '0;
      else if (dec_en) dly <= din;
    end
  end

  logic signed [AW-1:0] full;
  logic signed [AW-1:0] shf;
  logic [OW-1:0]        sat;
  assign full = cmb[ORDER-1].dout;
  assign shf  = full >>> SHIFT;

  always_comb begin
    if (shf > MAXV)      sat = MAXV[OW-1:0];
    else if (shf < MINV) sat = MINV[OW-1:0];
    else                 sat = shf[OW-1:0];
  end

  logic [SW-1:0] n_out;
  always_ff @(posedge clk) begin
    if (clr) begin
      n_out        <= '0;
      result       <= '0;
      result_valid <= 1'b0;
      settled      <= 1'b0;
    end else begin
      result_valid <= dec_en;
      if (dec_en) begin
        if (n_out != SETTLE) begin
          n_out  <= n_out + 1'b1;
          result <= '0;
        end else begin
          result  <= sat;
          settled <= 1'b1;
        end
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (clr)
    result_valid |=> !result_valid); // R2
  AST_SETTLED_HOLD: assert property (@(posedge clk) disable iff (clr)
    settled |=> settled); // R6
  AST_SETTLE_RISE: assert property (@(posedge clk) disable iff (clr)
    $rose(settled) |-> result_valid); // R6
  AST_QUIET_UNSETTLED: assert property (@(posedge clk) disable iff (clr)
    (result_valid && !settled) |-> (result == '0)); // R7
endmodule

// File: rtl/sinc5_decim.sv
module sinc5_decim
  import sinc5_pkg::*;
#(
  parameter int unsigned DIV   = DEF_DIV,
  parameter int unsigned LOG2R = DEF_LOG2R,
  parameter int unsigned ORDER = DEF_ORDER,
  parameter int unsigned OW    = DEF_OW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_clr,
  input  logic          mod_bit,
  output logic          mod_tick,
  output logic [OW-1:0] result,
  output logic          result_valid,
  output logic          settled
);
  localparam int unsigned AW = acc_width(ORDER, LOG2R);

  logic                 clr;
  logic                 dec_en;
  logic signed [AW-1:0] acc;

  assign clr = rst | sync_clr;

  sinc_tick_gen #(.DIV(DIV), .LOG2R(LOG2R)) i_tick (
    .clk(clk), .clr(clr), .tick(mod_tick), .dec_en(dec_en)
  );

  sinc_integ_chain #(.ORDER(ORDER), .AW(AW)) i_integ (
    .clk(clk), .clr(clr), .tick(mod_tick), .bit_in(mod_bit), .acc_out(acc)
  );

  sinc_comb_out #(.ORDER(ORDER), .LOG2R(LOG2R), .AW(AW), .OW(OW)) i_comb (
    .clk(clk), .clr(clr), .dec_en(dec_en), .acc_in(acc),
    .result(result), .result_valid(result_valid), .settled(settled)
  );

  AST_DEC_FOLLOWS_TICK: assert property (@(posedge clk) disable iff (clr)
    dec_en |-> $past(mod_tick)); // R2
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!result_valid && !settled && !mod_tick)); // R9
endmodule

// File: tb/test_sinc5_decim.sv
`timescale 1ns/1ps
module test_sinc5_decim;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sync_clr = 1'b0;
  logic        mod_bit = 1'b0;
  logic        mod_tick;
  logic [23:0] result;
  logic        result_valid;
  logic        settled;

  int n_chk = 0;
  int n_fail = 0;
  int pat = 1;
  int unsigned idx = 0;
  int lat_rst = 0;

  always #2.5 clk = ~clk;

  sinc5_decim i_sinc5_decim (
    .clk(clk), .rst(rst), .sync_clr(sync_clr), .mod_bit(mod_bit),
    .mod_tick(mod_tick), .result(result), .result_valid(result_valid),
    .settled(settled)
  );

  initial begin
    forever begin
      @(negedge clk);
      if (mod_tick) begin
        idx = idx + 1;
        case (pat)
          0: mod_bit = 1'b0;
          1: mod_bit = 1'b1;
          2: mod_bit = idx[0];
          3: mod_bit = (idx[1:0] != 2'd0);
          default: mod_bit = (idx[1:0] == 2'd0);
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_strobe(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!result_valid);
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    chk(result == 24'h0 && !result_valid, "R9 result/valid in reset", {result[22:0], result_valid}, 24'h0);
    chk(!settled && !mod_tick, "R9 settled/tick in reset", {22'h0, settled, mod_tick}, 24'h0);
  endtask

  task automatic t_settle;
    int n;
    rst = 1'b0;
    wait_strobe(lat_rst);
    for (int k = 1; k <= 6; k++) begin
      if (k > 1) begin
        wait_strobe(n);
        if (k <= 3) chk(n == 384, "R2 strobe interval", 24'(n), 24'd384);
      end
      if (k < 6) begin
        chk(!settled, "R6 unsettled before sixth", {23'h0, settled}, 24'h0);
        chk(result == 24'h0, "R7 word zero while unsettled", result, 24'h0);
      end else begin
        chk(settled, "R6 settled at sixth", {23'h0, settled}, 24'h1);
        chk(result == 24'h7fffff, "R5 positive saturation", result, 24'h7fffff);
      end
    end
    @(negedge clk);
    chk(!result_valid, "R2 strobe one clock", {23'h0, result_valid}, 24'h0);
  endtask

  task automatic t_tick;
    int n;
    while (!mod_tick) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      n = 0;
      do begin
        @(negedge clk);
        n++;
      end while (!mod_tick);
      chk(n == 6, "R1 tick interval", 24'(n), 24'd6);
    end
    @(negedge clk);
    chk(!mod_tick, "R1 tick one clock", {23'h0, mod_tick}, 24'h0);
  endtask

  task automatic t_value(input int p, input logic [23:0] exp, input string req);
    int n;
    pat = p;
    for (int k = 0; k < 7; k++) wait_strobe(n);
    for (int k = 0; k < 2; k++) begin
      chk(result == exp && settled, req, result, exp);
      wait_strobe(n);
    end
  endtask

  task automatic t_sync;
    int n;
    int lat;
    pat = 1;
    for (int k = 0; k < 7; k++) wait_strobe(n);
    repeat (100) @(negedge clk);
    sync_clr = 1'b1;
    pat = 3;
    @(negedge clk);
    sync_clr = 1'b0;
    chk(!settled, "R8 settled cleared", {23'h0, settled}, 24'h0);
    wait_strobe(lat);
    chk(lat == lat_rst, "R8 latency after clear", 24'(lat), 24'(lat_rst));
    for (int k = 1; k <= 6; k++) begin
      if (k > 1) wait_strobe(n);
      if (k < 6)
        chk(!settled && result == 24'h0, "R8 unsettled after clear", result, 24'h0);
      else
        chk(settled && result == 24'h400000, "R8 first settled word after clear", result, 24'h400000);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_settle();
    t_tick();
    t_value(0, 24'h800000, "R4 negative full scale");
    t_value(2, 24'h000000, "R3 alternating gives zero");
    t_value(3, 24'h400000, "R3 three quarters density");
    t_value(4, 24'hc00000, "R3 one quarter density");
    t_value(1, 24'h7fffff, "R5 saturation after pattern change");
    t_sync();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule